// File: doc/BRIEF.md
# Two-Channel Bus Break Comparator

This block sits beside a processor's bus and watches every access it makes: the address, the data, whether it reads or writes, whether it fetches an instruction or moves data, and how wide the access is. Two independent channels each hold a compare address, an address mask, a compare data word, a data mask and a control word of qualifiers. A channel hits when a valid access satisfies every qualifier it has turned on. The block then raises a one-cycle break request for the debug logic that follows it.

A sequential mode chains the channels into an ordered condition. A hit on channel 0 arms the unit, and only a later hit on channel 1 raises the break. The break clears the armed state. Software programs the channels through a small word-addressed register port. The same port reports a sticky hit flag for each channel and clears a flag when software writes 1 to it.

Register map (word address `reg_addr`): channel c (0 or 1) uses base `8*c`. Offset 0 is the compare address, 1 the address mask, 2 the compare data, 3 the data mask and 4 the control word. Address 7 is the mode/status word: bit0 selects sequential mode (read/write), bit1 and bit2 are the hit flags of channels 0 and 1 (write 1 clears), and bit3 is the armed state (read only). Control word: bit0 enables the channel, bit1 turns on the data compare, bits[3:2] set the direction, bits[5:4] set the access kind and bits[7:6] set the size.

Top module: `bus_break_unit`

## Requirements
- R1: The address condition holds when `(bus_addr ^ cmp_addr) & ~addr_mask` is zero. A mask bit of 1 ignores that bit.
- R2: With control bit1 set, the data condition holds when `(bus_data ^ cmp_data) & ~data_mask` is zero. With bit1 clear, data is ignored.
- R3: Direction field bits[3:2]: 01 accepts only reads (`bus_write`=0), 10 only writes, and 00 or 11 accept either.
- R4: Kind field bits[5:4]: 01 accepts only instruction fetches (`bus_ifetch`=1), 10 only data accesses, and 00 or 11 accept either.
- R5: Size field bits[7:6]: 00 accepts any `bus_size`. Otherwise the field must equal `bus_size` (01 byte, 10 word, 11 longword).
- R6: With sequential mode off, `break_req` is high in the cycle after any enabled channel hits a `bus_valid` access, and low otherwise. With `bus_valid` low or control bit0 clear, a channel never hits.
- R7: With sequential mode on, a channel 0 hit arms the unit. `break_req` rises in the cycle after a channel 1 hit only if the unit was already armed before that access. A channel 1 hit that arrives together with the arming hit, or with no arming hit before it, raises no break.
- R8: A break in sequential mode clears the armed state, unless channel 0 hits in the same access. Turning sequential mode off also clears it. The armed state reads back at status bit3.
- R9: A channel's hit flag sets in the cycle after any hit, in either mode, and stays set until software writes 1 to its status bit. A hit in the same cycle as that clear wins.
- R10: After reset every register reads 0 and `break_req` is low. Written fields read back unchanged (control word: 8 bits).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_valid | input | 1 | Access strobe |
| bus_addr | input | AW | Access address |
| bus_data | input | DW | Access data |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_ifetch | input | 1 | 1 for instruction fetch, 0 for data |
| bus_size | input | 2 | 01 byte, 10 word, 11 longword |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| break_req | output | 1 | One-cycle break request |

## Verification
A wrong armed state shows up on `break_req` at the first channel 1 hit after it goes wrong. It either breaks without any earlier channel 0 hit or stays silent after one. It also shows at status bit3 in the same cycle it changes. A fault in a qualifier or mask changes `break_req` one cycle after the access and sets the sticky flag. Because the flag holds, a read at any later time exposes the fault even after the pulse has gone. The bench drives random configurations and accesses biased toward near-matches against a cycle model. It also runs directed cases for the same-cycle A/B hit, a clear that collides with a set, and leaving sequential mode while armed.

// File: rtl/bbk_pkg.sv
// Shared types and encodings for the bus break comparator.
package bbk_pkg;
    localparam int NCH = 2;

    // Direction, kind and size encodings of the per-channel control word.
    localparam logic [1:0] DIR_RD   = 2'b01;
    localparam logic [1:0] DIR_WR   = 2'b10;
    localparam logic [1:0] KIND_IF  = 2'b01;
    localparam logic [1:0] KIND_DAT = 2'b10;
    localparam logic [1:0] SZ_ANY   = 2'b00;

    // Control word layout, LSB first: enable, data compare, dir, kind, size.
    typedef struct packed {
        logic [1:0] size;
        logic [1:0] kind;
        logic [1:0] dir;
        logic       use_data;
        logic       en;
    } chan_ctrl_t;

    // Register word addresses.
    localparam logic [2:0] OFS_ADDR  = 3'd0;
    localparam logic [2:0] OFS_AMASK = 3'd1;
    localparam logic [2:0] OFS_DATA  = 3'd2;
    localparam logic [2:0] OFS_DMASK = 3'd3;
    localparam logic [2:0] OFS_CTRL  = 3'd4;
    localparam logic [3:0] ADR_MODE  = 4'd7;
endpackage

// File: rtl/bbk_chan_cmp.sv
// Combinational qualifier check for one break channel.
// Assumes the inputs are stable within the cycle; the output is a plain hit.
module bbk_chan_cmp
    import bbk_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          bus_valid,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_data,
    input  logic          bus_write,
    input  logic          bus_ifetch,
    input  logic [1:0]    bus_size,
    input  logic [AW-1:0] cmp_addr,
    input  logic [AW-1:0] addr_mask,
    input  logic [DW-1:0] cmp_data,
    input  logic [DW-1:0] data_mask,
    input  chan_ctrl_t    ctrl,
    output logic          hit
);
    logic addr_ok, data_ok, dir_ok, kind_ok, size_ok;

    // Masked address and data equality.
    always_comb begin
        addr_ok = ~|((bus_addr ^ cmp_addr) & ~addr_mask);
        data_ok = !ctrl.use_data || ~|((bus_data ^ cmp_data) & ~data_mask);
    end

    // Access-type and size qualifiers.
    always_comb begin
        unique case (ctrl.dir)
            DIR_RD:  dir_ok = !bus_write;
            DIR_WR:  dir_ok = bus_write;
            default: dir_ok = 1'b1;
        endcase
        unique case (ctrl.kind)
            KIND_IF:  kind_ok = bus_ifetch;
            KIND_DAT: kind_ok = !bus_ifetch;
            default:  kind_ok = 1'b1;
        endcase
        size_ok = (ctrl.size == SZ_ANY) || (ctrl.size == bus_size);
    end

    // All conditions together.
    always_comb hit = bus_valid && ctrl.en && addr_ok && data_ok && dir_ok && kind_ok && size_ok;
endmodule

// File: rtl/bbk_regs.sv
// Register file: channel compare values, masks, control words, the mode bit
// and the sticky per-channel hit flags (write 1 to clear, set wins).
// Assumes AW and DW are at most RW.
module bbk_regs
    import bbk_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int RW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [3:0]    reg_addr,
    input  logic [RW-1:0] reg_wdata,
    output logic [RW-1:0] reg_rdata,
    input  logic [NCH-1:0] hit,
    input  logic          armed,
    output logic [AW-1:0] cmp_addr  [NCH],
    output logic [AW-1:0] addr_mask [NCH],
    output logic [DW-1:0] cmp_data  [NCH],
    output logic [DW-1:0] data_mask [NCH],
    output chan_ctrl_t    ctrl      [NCH],
    output logic          seq_en
);
    localparam int CW = $bits(chan_ctrl_t);

    logic [NCH-1:0] flag;
    logic           mode_wr;

    always_comb mode_wr = reg_wr && (reg_addr == ADR_MODE);

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic sel;
        always_comb sel = reg_wr && (reg_addr[3] == c[0]);

        // Channel configuration storage.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cmp_addr[c]  <= '0;
                addr_mask[c] <= '0;
                cmp_data[c]  <= '0;
                data_mask[c] <= '0;
                ctrl[c]      <= '0;
            end else if (sel) begin
                case (reg_addr[2:0])
                    OFS_ADDR:  cmp_addr[c]  <= reg_wdata[AW-1:0];
                    OFS_AMASK: addr_mask[c] <= reg_wdata[AW-1:0];
                    OFS_DATA:  cmp_data[c]  <= reg_wdata[DW-1:0];
                    OFS_DMASK: data_mask[c] <= reg_wdata[DW-1:0];
                    OFS_CTRL:  ctrl[c]      <= chan_ctrl_t'(reg_wdata[CW-1:0]);
                    default: ;
                endcase
            end
        end

        // Sticky hit flag, cleared by writing 1; a new hit takes precedence.
        always_ff @(posedge clk) begin
            if (!rst_n)
                flag[c] <= 1'b0;
            else if (hit[c])
                flag[c] <= 1'b1;
            else if (mode_wr && reg_wdata[1+c])
                flag[c] <= 1'b0;
        end

        p_flag_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
            hit[c] |=> flag[c]);
        p_flag_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (flag[c] && !(mode_wr && reg_wdata[1+c])) |=> flag[c]);
    end

    // Mode bit storage.
    always_ff @(posedge clk) begin
        if (!rst_n)
            seq_en <= 1'b0;
        else if (mode_wr)
            seq_en <= reg_wdata[0];
    end

    // Read multiplexer.
    always_comb begin
        logic [0:0] ci;
        ci = reg_addr[3];
        reg_rdata = '0;
        if (reg_addr == ADR_MODE) begin
            reg_rdata[0] = seq_en;
            reg_rdata[2:1] = flag;
            reg_rdata[3] = armed;
        end else begin
            case (reg_addr[2:0])
                OFS_ADDR:  reg_rdata = RW'(cmp_addr[ci]);
                OFS_AMASK: reg_rdata = RW'(addr_mask[ci]);
                OFS_DATA:  reg_rdata = RW'(cmp_data[ci]);
                OFS_DMASK: reg_rdata = RW'(data_mask[ci]);
                OFS_CTRL:  reg_rdata = RW'(ctrl[ci]);
                default:   reg_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/bbk_seq.sv
// Break sequencer: direct OR of the channel hits, or ordered
// channel-0-then-channel-1 with an armed state. Registered one-cycle output.
module bbk_seq
    import bbk_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] hit,
    input  logic           seq_en,
    output logic           armed,
    output logic           break_req
);
    logic fire;

    // Break decision for this access.
    always_comb fire = seq_en ? (armed && hit[1]) : (|hit);

    // Armed state and break pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed     <= 1'b0;
            break_req <= 1'b0;
        end else begin
            break_req <= fire;
            if (!seq_en)
                armed <= 1'b0;
            else if (hit[0])
                armed <= 1'b1;
            else if (fire)
                armed <= 1'b0;
        end
    end

    p_direct_break_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!seq_en && |hit) |=> break_req);
    p_no_hit_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(|hit) |=> !break_req);
    p_seq_needs_arm_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_en && !armed) |=> !break_req);
    p_arm_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_en && armed && hit[1] && !hit[0]) |=> !armed);
endmodule

// File: rtl/bus_break_unit.sv
// Two-channel bus break comparator top. Watches a bus access stream and
// raises a one-cycle break request one cycle after a qualifying access.
// Assumes a single clock and synchronous active-low reset.
module bus_break_unit
    import bbk_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_valid,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_data,
    input  logic          bus_write,
    input  logic          bus_ifetch,
    input  logic [1:0]    bus_size,
    input  logic          reg_wr,
    input  logic [3:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    output logic          break_req
);
    logic [AW-1:0] cmp_addr  [NCH];
    logic [AW-1:0] addr_mask [NCH];
    logic [DW-1:0] cmp_data  [NCH];
    logic [DW-1:0] data_mask [NCH];
    chan_ctrl_t    ctrl      [NCH];
    logic [NCH-1:0] hit;
    logic          seq_en, armed;

    bbk_regs #(.AW(AW), .DW(DW), .RW(32)) regs_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hit(hit), .armed(armed),
        .cmp_addr(cmp_addr), .addr_mask(addr_mask), .cmp_data(cmp_data),
        .data_mask(data_mask), .ctrl(ctrl), .seq_en(seq_en)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_cmp
        bbk_chan_cmp #(.AW(AW), .DW(DW)) cmp_i (
            .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_data(bus_data),
            .bus_write(bus_write), .bus_ifetch(bus_ifetch), .bus_size(bus_size),
            .cmp_addr(cmp_addr[c]), .addr_mask(addr_mask[c]),
            .cmp_data(cmp_data[c]), .data_mask(data_mask[c]),
            .ctrl(ctrl[c]), .hit(hit[c])
        );
    end

    bbk_seq seq_i (
        .clk(clk), .rst_n(rst_n), .hit(hit), .seq_en(seq_en),
        .armed(armed), .break_req(break_req)
    );

    p_idle_no_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_valid |=> !break_req);
endmodule

// File: tb/bus_break_unit_tb_top.sv
module bus_break_unit_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_valid = 0, bus_write = 0, bus_ifetch = 0;
    logic [31:0] bus_addr = 0, bus_data = 0;
    logic [1:0] bus_size = 0;
    logic reg_wr = 0;
    logic [3:0] reg_addr = 0;
    logic [31:0] reg_wdata = 0;
    logic [31:0] reg_rdata;
    logic break_req;

    int n_chk = 0, n_err = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    bus_break_unit dut_i (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_addr(bus_addr),
        .bus_data(bus_data), .bus_write(bus_write), .bus_ifetch(bus_ifetch),
        .bus_size(bus_size), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .break_req(break_req)
    );

    // Shadow model state.
    logic [31:0] m_addr[2], m_amask[2], m_data[2], m_dmask[2];
    logic [7:0]  m_ctrl[2];
    logic m_seq, m_armed;
    logic [1:0] m_flag;

    function automatic bit model_hit(int c, bit v, logic [31:0] a, logic [31:0] d,
                                     bit wr, bit fi, logic [1:0] sz);
        logic [7:0] k = m_ctrl[c];
        bit ok;
        ok = v && k[0];
        ok = ok && (((a ^ m_addr[c]) & ~m_amask[c]) == 0);
        ok = ok && (!k[1] || (((d ^ m_data[c]) & ~m_dmask[c]) == 0));
        ok = ok && !((k[3:2] == 2'b01 && wr) || (k[3:2] == 2'b10 && !wr));
        ok = ok && !((k[5:4] == 2'b01 && !fi) || (k[5:4] == 2'b10 && fi));
        ok = ok && (k[7:6] == 2'b00 || k[7:6] == sz);
        return ok;
    endfunction

    function automatic logic [31:0] model_read(logic [3:0] ra);
        int c = ra[3];
        if (ra == 4'd7) return {28'd0, m_armed, m_flag, m_seq};
        case (ra[2:0])
            3'd0: return m_addr[c];
            3'd1: return m_amask[c];
            3'd2: return m_data[c];
            3'd3: return m_dmask[c];
            3'd4: return {24'd0, m_ctrl[c]};
            default: return 32'd0;
        endcase
    endfunction

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One clock: drive bus and optional write at negedge, check at next negedge.
    task automatic step(bit v, logic [31:0] a, logic [31:0] d, bit wr, bit fi,
                        logic [1:0] sz, bit rw, logic [3:0] ra, logic [31:0] wd,
                        string req);
        bit h0, h1, fire;
        bus_valid = v; bus_addr = a; bus_data = d; bus_write = wr;
        bus_ifetch = fi; bus_size = sz; reg_wr = rw; reg_addr = ra; reg_wdata = wd;
        h0 = model_hit(0, v, a, d, wr, fi, sz);
        h1 = model_hit(1, v, a, d, wr, fi, sz);
        fire = m_seq ? (m_armed && h1) : (h0 || h1);
        @(posedge clk);
        if (!m_seq) m_armed = 0;
        else if (h0) m_armed = 1;
        else if (fire) m_armed = 0;
        for (int c = 0; c < 2; c++) begin
            if (h0 && c == 0 || h1 && c == 1) m_flag[c] = 1;
            else if (rw && ra == 4'd7 && wd[1+c]) m_flag[c] = 0;
        end
        if (rw) begin
            int c = ra[3];
            if (ra == 4'd7) m_seq = wd[0];
            else case (ra[2:0])
                3'd0: m_addr[c] = wd;
                3'd1: m_amask[c] = wd;
                3'd2: m_data[c] = wd;
                3'd3: m_dmask[c] = wd;
                3'd4: m_ctrl[c] = wd[7:0];
                default: ;
            endcase
        end
        @(negedge clk);
        bus_valid = 0; reg_wr = 0;
        check(break_req == fire, req, {31'd0, break_req}, {31'd0, fire});
    endtask

    task automatic wr_reg(logic [3:0] ra, logic [31:0] wd);
        step(0, 0, 0, 0, 0, 0, 1, ra, wd, "R10 write");
    endtask

    task automatic acc(logic [31:0] a, logic [31:0] d, bit wr, bit fi,
                       logic [1:0] sz, string req);
        step(1, a, d, wr, fi, sz, 0, 0, 0, req);
    endtask

    task automatic rd(logic [3:0] ra, string req);
        logic [31:0] e = model_read(ra);
        reg_addr = ra; #0.5;
        check(reg_rdata == e, req, reg_rdata, e);
    endtask

    initial begin
        for (int c = 0; c < 2; c++) begin
            m_addr[c] = 0; m_amask[c] = 0; m_data[c] = 0; m_dmask[c] = 0; m_ctrl[c] = 0;
        end
        m_seq = 0; m_armed = 0; m_flag = 0;
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R10: reset state.
        check(break_req == 0, "R10 reset break", {31'd0, break_req}, 0);
        for (int r = 0; r < 16; r++) rd(4'(r), "R10 reset read");

        // R1/R6: address with mask, channel 0, no other qualifiers.
        wr_reg(4'd0, 32'h1000_0040);
        wr_reg(4'd1, 32'h0000_000F);
        wr_reg(4'd4, 32'h01);
        for (int r = 0; r < 16; r++) rd(4'(r), "R10 readback");
        acc(32'h1000_004C, 0, 0, 0, 2'b11, "R1 masked bit hit");
        acc(32'h1000_0050, 0, 0, 0, 2'b11, "R1 unmasked bit miss");
        step(0, 32'h1000_0040, 0, 0, 0, 2'b11, 0, 0, 0, "R6 invalid access");
        // R2: data compare.
        wr_reg(4'd2, 32'hCAFE_0000);
        wr_reg(4'd3, 32'h0000_FFFF);
        wr_reg(4'd4, 32'h03);
        acc(32'h1000_0040, 32'hCAFE_1234, 0, 0, 2'b01, "R2 data hit");
        acc(32'h1000_0040, 32'hCAFF_1234, 0, 0, 2'b01, "R2 data miss");
        // R3/R4/R5 qualifiers: write only, data kind, word size.
        wr_reg(4'd4, 8'b10_10_10_01);
        acc(32'h1000_0040, 0, 1, 0, 2'b10, "R3 write accepted");
        acc(32'h1000_0040, 0, 0, 0, 2'b10, "R3 read rejected");
        acc(32'h1000_0040, 0, 1, 1, 2'b10, "R4 fetch rejected");
        acc(32'h1000_0040, 0, 1, 0, 2'b01, "R5 size mismatch");
        wr_reg(4'd4, 8'b00_01_01_01);
        acc(32'h1000_0040, 0, 0, 1, 2'b01, "R5 any size fetch read");
        rd(4'd7, "R9 flag after hits");
        wr_reg(4'd7, 32'h2);
        rd(4'd7, "R9 flag cleared");

        // R7/R8: sequential mode. ch1 at 0x2000 any.
        wr_reg(4'd8, 32'h2000_0000);
        wr_reg(4'd12, 32'h01);
        wr_reg(4'd4, 32'h01);
        wr_reg(4'd7, 32'h1);
        acc(32'h2000_0000, 0, 0, 0, 2'b11, "R7 B without arm");
        acc(32'h1000_0040, 0, 0, 0, 2'b11, "R7 A arms");
        rd(4'd7, "R8 armed visible");
        acc(32'h2000_0000, 0, 0, 0, 2'b11, "R7 B after A fires");
        rd(4'd7, "R8 armed cleared");
        // Both channels hit same access: set ch1 to A's address too.
        wr_reg(4'd8, 32'h1000_0040);
        acc(32'h1000_0040, 0, 0, 0, 2'b11, "R7 same-cycle A and B no break");
        acc(32'h1000_0040, 0, 0, 0, 2'b11, "R8 armed+A+B fires and rearms");
        rd(4'd7, "R8 still armed");
        wr_reg(4'd7, 32'h0);
        rd(4'd7, "R8 seq off clears arm");
        // R9: clear colliding with a hit: set wins.
        step(1, 32'h1000_0040, 0, 0, 0, 2'b11, 1, 4'd7, 32'h6, "R9 set beats clear");
        rd(4'd7, "R9 flags after collision");

        // Random phase.
        for (int it = 0; it < 3000; it++) begin
            int k = $urandom_range(0, 19);
            if (k == 0) begin
                int c = $urandom_range(0, 1);
                logic [2:0] f = 3'($urandom_range(0, 4));
                logic [31:0] w = $urandom;
                if (f == 1 || f == 3) w = ($urandom_range(0, 1) != 0) ? 32'h0 : 32'h0000_00FF;
                if (f == 4) w = {24'd0, w[7:1], 1'b1};
                wr_reg({c[0], f}, w);
            end else if (k == 1) begin
                wr_reg(4'd7, $urandom);
            end else if (k == 2) begin
                rd(4'($urandom_range(0, 15)), "R10 random read");
            end else begin
                int c = $urandom_range(0, 1);
                logic [31:0] a = m_addr[c] ^ (($urandom_range(0, 2) == 0) ? $urandom : ($urandom & 32'h1FF));
                logic [31:0] d = m_data[c] ^ (($urandom_range(0, 2) == 0) ? $urandom : ($urandom & 32'h1FF));
                step(1'($urandom_range(0, 7) != 0), a, d, 1'($urandom), 1'($urandom),
                     2'($urandom), 0, 0, 0, "R6 R7 random access");
            end
        end
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                n_chk++; n_err++;
                $display("FAIL watchdog actual=running expected=done");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule